// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a simple register bus and a one-time-programmable fuse array. Software selects an operation in a command register, gives a row address and, for programming, the row data. It then raises a start bit and polls a status register until the done flag appears. The fuse array is modelled as a register array inside the block. Each row is `ROW_WORDS` 32-bit words wide (one or two). A read copies the addressed row into read-back registers.

Programming is locked after reset. Software unlocks it by issuing the enable command four times, with a fixed run of key values in the first write-data word. Once unlocked, a program command can only turn fuse bits on. The time it takes grows with the number of ones in the data. A disable command locks the array again.

Bus reads return register contents combinationally from `bus_addr`. Bus writes take effect on the rising clock edge at which `bus_wr` is high.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, every register reads zero. The register offsets are: control-enable 0x00 (bit 0), command 0x04, start 0x08 (bit 0), status 0x0C, read word 0 at 0x10, row address 0x28, write word 0 at 0x2C, read word 1 at 0x5C and write word 1 at 0x64. Each writable register reads back what was written.
- R2: Only the low 6 bits of the command register and the low 16 bits of the address register are stored. Higher written bits read back as zero.
- R3: A start request is ignored while control-enable bit 0 is clear. The done flag (status bit 1) stays low.
- R4: An operation launches only on a 0-to-1 change of start bit 0, and only when no operation is running. The done flag falls when an operation launches and rises when it completes. Writing 1 to the start bit again while it is already 1 launches nothing.
- R5: The read command (0x00) takes `READ_LAT` cycles and loads the addressed row into the read-back registers. A row address of `NUM_ROWS` or above loads zeros.
- R6: The enable command (0x02) advances an unlock counter when write word 0 equals the next key in the order 0xF, 0x4, 0x8, 0xD. Programming-OK (status bit 2) rises when the fourth key completes. Each enable step takes `CTRL_LAT` cycles.
- R7: An enable command carrying a value other than the expected key returns the unlock counter to its first step.
- R8: The disable command (0x03) clears programming-OK and the unlock counter, and takes `CTRL_LAT` cycles.
- R9: A program command (0x08) issued while programming-OK is low completes with done set and leaves the array unchanged.
- R10: When unlocked, a program command ORs the write words into the addressed row, so no fuse bit ever returns to 0. A row address of `NUM_ROWS` or above changes nothing.
- R11: A program command takes `PROG_BASE + PROG_PER_BIT * (number of ones in the row data)` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |

## Verification
The assertions check the following on every cycle:
- no fuse bit ever falls;
- a row changes only while programming-OK is held;
- done stays low while an operation is running;
- nothing launches with control-enable clear;
- programming-OK rises only at the fourth correct key;
- a disable always leaves the block locked.

Only the bench scenarios show the remaining behaviour: the exact cycle counts of each operation type, the ones-count scaling of program time, the return of the unlock counter to its first step after a wrong key, the zeros returned for out-of-range rows, and the masking of the command and address fields.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int ROW_WORDS    = 2,
  parameter int NUM_ROWS     = 16,
  parameter int READ_LAT     = 4,
  parameter int CTRL_LAT     = 2,
  parameter int PROG_BASE    = 3,
  parameter int PROG_PER_BIT = 2,
  parameter int LAT_W        = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int ROW_W  = 32 * ROW_WORDS;
  localparam int ROW_AW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int CNT_W  = $clog2(ROW_W + 1);

  localparam logic [5:0] CMD_READ = 6'h00;
  localparam logic [5:0] CMD_EN   = 6'h02;
  localparam logic [5:0] CMD_DIS  = 6'h03;
  localparam logic [5:0] CMD_PROG = 6'h08;

  localparam logic [7:0] A_MODE  = 8'h00;
  localparam logic [7:0] A_CMD   = 8'h04;
  localparam logic [7:0] A_START = 8'h08;
  localparam logic [7:0] A_STAT  = 8'h0C;
  localparam logic [7:0] A_RD0   = 8'h10;
  localparam logic [7:0] A_ADDR  = 8'h28;
  localparam logic [7:0] A_WD0   = 8'h2C;
  localparam logic [7:0] A_RD1   = 8'h5C;
  localparam logic [7:0] A_WD1   = 8'h64;

  logic             mode_q, start_q, done_q, ok_q, busy_q;
  logic [5:0]       cmd_q, op_cmd;
  logic [15:0]      addr_q, op_addr;
  logic [ROW_W-1:0] wd_q, rd_q, op_data;
  logic [LAT_W-1:0] cnt_q, lat;
  logic [2:0]       step_q;
  logic [ROW_W-1:0] fuse [NUM_ROWS];

  function automatic logic [CNT_W-1:0] ones(input logic [ROW_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < ROW_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [31:0] key_at(input logic [2:0] s);
    case (s)
      3'd0:    return 32'hF;
      3'd1:    return 32'h4;
      3'd2:    return 32'h8;
      default: return 32'hD;
    endcase
  endfunction

  wire wr_start = bus_wr && bus_addr == A_START;
  wire launch   = wr_start && bus_wdata[0] && !start_q && mode_q && !busy_q;
  wire finish   = busy_q && cnt_q == '0;
  wire in_range = op_addr < 16'(NUM_ROWS);
  wire [ROW_AW-1:0] row = op_addr[ROW_AW-1:0];

  always_comb begin
    case (cmd_q)
      CMD_READ: lat = LAT_W'(READ_LAT);
      CMD_PROG: lat = LAT_W'(PROG_BASE) + LAT_W'(PROG_PER_BIT) * LAT_W'(ones(wd_q));
      default:  lat = LAT_W'(CTRL_LAT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      cmd_q   <= '0;
      start_q <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q  <= bus_wdata[0];
        A_CMD:   cmd_q   <= bus_wdata[5:0];
        A_START: start_q <= bus_wdata[0];
        A_ADDR:  addr_q  <= bus_wdata[15:0];
        A_WD0:   wd_q[31:0] <= bus_wdata;
        A_WD1:   if (ROW_WORDS > 1) wd_q[ROW_W-1 -: 32] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      step_q  <= '0;
      cnt_q   <= '0;
      op_cmd  <= '0;
      op_addr <= '0;
      op_data <= '0;
      rd_q    <= '0;
      for (int i = 0; i < NUM_ROWS; i++) fuse[i] <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= lat - 1'b1;
      op_cmd  <= cmd_q;
      op_addr <= addr_q;
      op_data <= wd_q;
    end else if (busy_q && !finish) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (finish) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      case (op_cmd)
        CMD_READ: rd_q <= in_range ? fuse[row] : '0;
        CMD_EN: if (!ok_q) begin
          if (op_data[31:0] == key_at(step_q)) begin
            step_q <= step_q + 1'b1;
            if (step_q == 3'd3) ok_q <= 1'b1;
          end else begin
            step_q <= '0;
          end
        end
        CMD_DIS: begin
          ok_q   <= 1'b0;
          step_q <= '0;
        end
        CMD_PROG: if (ok_q && in_range) fuse[row] <= fuse[row] | op_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = {31'b0, mode_q};
      A_CMD:   bus_rdata = {26'b0, cmd_q};
      A_START: bus_rdata = {31'b0, start_q};
      A_STAT:  bus_rdata = {29'b0, ok_q, done_q, 1'b0};
      A_RD0:   bus_rdata = rd_q[31:0];
      A_ADDR:  bus_rdata = {16'b0, addr_q};
      A_WD0:   bus_rdata = wd_q[31:0];
      A_RD1:   if (ROW_WORDS > 1) bus_rdata = rd_q[ROW_W-1 -: 32];
      A_WD1:   if (ROW_WORDS > 1) bus_rdata = wd_q[ROW_W-1 -: 32];
      default: ;
    endcase
  end

  p_launch_needs_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(mode_q));

  p_done_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);

  p_ok_after_fourth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> ($past(step_q) == 3'd3 && $past(op_cmd) == CMD_EN));

  p_disable_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(finish) && $past(op_cmd) == CMD_DIS) |-> (!ok_q && step_q == '0));

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_fuse_chk
    p_fuse_only_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(fuse[g]) & ~fuse[g]) == '0));
    p_fuse_needs_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse[g] != $past(fuse[g])) |-> $past(ok_q));
  end
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  otp_fuse_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // op 0 = write, 1 = read and compare, 2 = run command (data) and compare latency (exp)
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h04, 32'hFFFF_FFC8, 32'h0},        // R2
    {2'd1, 8'h04, 32'h0, 32'h0000_0008},
    {2'd0, 8'h28, 32'hABCD_0003, 32'h0},        // R2
    {2'd1, 8'h28, 32'h0, 32'h0000_0003},
    {2'd0, 8'h2C, 32'h1234_5678, 32'h0},        // R1
    {2'd1, 8'h2C, 32'h0, 32'h1234_5678},
    {2'd0, 8'h64, 32'h9ABC_DEF0, 32'h0},        // R1
    {2'd1, 8'h64, 32'h0, 32'h9ABC_DEF0},
    {2'd0, 8'h00, 32'hFFFF_FFFF, 32'h0},        // R1
    {2'd1, 8'h00, 32'h0, 32'h1},
    {2'd2, 8'h00, 32'h8, 32'd67},               // R9 R11 locked program
    {2'd2, 8'h00, 32'h0, 32'd4},                // R5
    {2'd1, 8'h10, 32'h0, 32'h0},                // R9
    {2'd1, 8'h5C, 32'h0, 32'h0},
    {2'd0, 8'h2C, 32'hF, 32'h0},                // R6
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'h4, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'h8, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd1, 8'h0C, 32'h0, 32'h2},                // R6 not yet unlocked
    {2'd0, 8'h2C, 32'hD, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd1, 8'h0C, 32'h0, 32'h6},                // R6 unlocked
    {2'd0, 8'h2C, 32'h0000_00F0, 32'h0},
    {2'd0, 8'h64, 32'h1, 32'h0},
    {2'd2, 8'h00, 32'h8, 32'd13},               // R11
    {2'd2, 8'h00, 32'h0, 32'd4},                // R5
    {2'd1, 8'h10, 32'h0, 32'h0000_00F0},
    {2'd1, 8'h5C, 32'h0, 32'h1},
    {2'd0, 8'h2C, 32'hF, 32'h0},
    {2'd0, 8'h64, 32'h0, 32'h0},
    {2'd2, 8'h00, 32'h8, 32'd11},               // R11
    {2'd2, 8'h00, 32'h0, 32'd4},
    {2'd1, 8'h10, 32'h0, 32'h0000_00FF},        // R10 OR
    {2'd1, 8'h5C, 32'h0, 32'h1},                // R10 kept
    {2'd0, 8'h28, 32'h20, 32'h0},
    {2'd0, 8'h2C, 32'hFFFF_FFFF, 32'h0},
    {2'd0, 8'h64, 32'hFFFF_FFFF, 32'h0},
    {2'd2, 8'h00, 32'h8, 32'd131},              // R11 all ones
    {2'd2, 8'h00, 32'h0, 32'd4},
    {2'd1, 8'h10, 32'h0, 32'h0},                // R5 out of range
    {2'd1, 8'h5C, 32'h0, 32'h0},
    {2'd0, 8'h28, 32'h3, 32'h0},
    {2'd2, 8'h00, 32'h0, 32'd4},
    {2'd1, 8'h10, 32'h0, 32'h0000_00FF},        // R10 out of range ignored
    {2'd2, 8'h00, 32'h3, 32'd2},                // R8
    {2'd1, 8'h0C, 32'h0, 32'h2},
    {2'd0, 8'h2C, 32'hFFFF_0000, 32'h0},
    {2'd0, 8'h64, 32'h0, 32'h0},
    {2'd2, 8'h00, 32'h8, 32'd35},               // R9 after disable
    {2'd2, 8'h00, 32'h0, 32'd4},
    {2'd1, 8'h10, 32'h0, 32'h0000_00FF},
    {2'd0, 8'h2C, 32'hF, 32'h0},                // R7
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'h4, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'h5, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'h8, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd0, 8'h2C, 32'hD, 32'h0},
    {2'd2, 8'h00, 32'h2, 32'd2},
    {2'd1, 8'h0C, 32'h0, 32'h2}                 // R7 still locked
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_cmd(input logic [5:0] c, input int exp_lat, input string req);
    logic [31:0] st;
    int n;
    bus_write(8'h04, {26'b0, c});
    bus_write(8'h08, 32'h1);
    n = 0;
    bus_read(8'h0C, st);
    while (!st[1] && n < 10000) begin
      @(negedge clk);
      n++;
      bus_read(8'h0C, st);
    end
    check(req, n, exp_lat);
    bus_write(8'h08, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_read(8'h0C, r); check("R1 status reset", r, 32'h0);
    bus_read(8'h10, r); check("R1 read word reset", r, 32'h0);
    bus_read(8'h28, r); check("R1 address reset", r, 32'h0);
    bus_read(8'h00, r); check("R1 mode reset", r, 32'h0);
    // R3 start ignored with control-enable clear
    bus_write(8'h08, 32'h1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      bus_read(8'h0C, r);
      if (r[1]) break;
    end
    check("R3 no done without enable", r, 32'h0);
    bus_write(8'h08, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: bus_write(a, d);
        2'd1: begin bus_read(a, r); check($sformatf("R1-R10 vector %0d", i), r, e); end
        default: run_cmd(d[5:0], int'(e), $sformatf("R5-R11 latency vector %0d", i));
      endcase
    end

    // R4 re-writing start=1 while held high launches nothing
    bus_write(8'h04, 32'h0);
    bus_write(8'h08, 32'h1);
    repeat (8) @(negedge clk);
    bus_read(8'h0C, r); check("R4 first launch done", r, 32'h2);
    bus_write(8'h08, 32'h1);
    bus_read(8'h0C, r); check("R4 no relaunch next cycle", r, 32'h2);
    repeat (6) @(negedge clk);
    bus_read(8'h0C, r); check("R4 no relaunch later", r, 32'h2);
    bus_write(8'h08, 32'h0);
    // R4 done falls on a new launch
    bus_write(8'h08, 32'h1);
    bus_read(8'h0C, r); check("R4 done falls on launch", r, 32'h0);
    repeat (6) @(negedge clk);
    bus_write(8'h08, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule